// File: doc/BRIEF.md
# Power-of-Two Descriptor Ring Consumer

This block sits on the device side of a transmit or receive descriptor ring. Host software owns the producer side. It announces new work by writing a free-running 32-bit producer count to a doorbell. The block reads fixed-size descriptors out of ring memory strictly in order and hands each one downstream with its ring slot. After every accepted descriptor it publishes its own free-running consumed count. Both counts are 32 bits wide, wrap from `0xFFFFFFFF` to zero, and are turned into ring slots by keeping only the low `RING_LOG2` bits.

Both 32-bit words cross the block edge in big-endian byte order. On these ports, byte lane 0 (bits [7:0]) carries the most significant byte and lane 3 (bits [31:24]) the least. When `IS_RX` is set, the block also reports the slot of a companion data-buffer ring of the same length. That ring is indexed by the same pointer, so it advances in lockstep with the descriptor ring. The parameter `START_COUNT` sets the value both counts take at reset.

The consumer is a three-state machine:
- `ST_IDLE` issues a memory read for the slot at the consumed count whenever work is pending, and moves to `ST_FETCH`. With no work pending it stays in `ST_IDLE`.
- `ST_FETCH` always moves to `ST_PRESENT`, capturing the read data on the way.
- `ST_PRESENT` holds the descriptor valid. It returns to `ST_IDLE` on a downstream handshake, which also advances the consumed count. Without a handshake it stays in `ST_PRESENT`.

Top module: `desc_ring_consumer`

## Requirements
- R1: After reset the published consumed count equals `START_COUNT`, `out_valid` is 0, `db_err` is 0 and no memory read is issued.
- R2: The doorbell word and the published count are byte-reversed relative to their numeric value: bits [7:0] carry the most significant byte and bits [31:24] the least significant byte.
- R3: The pending count is the producer count minus the consumed count, modulo 2^32. A memory read is issued only while the pending count is nonzero, and with nothing pending `out_valid` stays 0.
- R4: Descriptors are delivered strictly in order. Each one is read from slot `count & (2^RING_LOG2 - 1)` with a read latency of one cycle. `out_desc` equals that slot's memory word and `out_slot` equals that slot.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_desc` and `out_slot` stay unchanged. After the stall, delivery resumes with no descriptor skipped or repeated.
- R6: The consumed count rises by exactly one per accepted descriptor. The published value reflects an acceptance at the clock edge where `out_valid` and `out_ready` are both 1.
- R7: Both counts wrap from `0xFFFFFFFF` to zero. Pending work and slot selection stay correct across the wrap.
- R8: A doorbell value whose distance ahead of the consumed count, modulo 2^32, exceeds the ring size is rejected. The producer count is left unchanged, and `db_err` pulses high for the cycle after the write.
- R9: With `IS_RX` set, `out_data_slot` equals `out_slot` for every delivered descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_value_be | input | 32 | Producer count, big-endian byte order |
| db_err | output | 1 | Pulses for one cycle when a doorbell value is rejected |
| mem_rd_en | output | 1 | Descriptor memory read request |
| mem_rd_slot | output | RING_LOG2 | Ring slot to read |
| mem_rd_data | input | DESC_W | Descriptor word, valid one cycle after the request |
| out_valid | output | 1 | Descriptor presented downstream |
| out_ready | input | 1 | Downstream accepts the descriptor |
| out_desc | output | DESC_W | Descriptor word |
| out_slot | output | RING_LOG2 | Descriptor ring slot |
| out_data_slot | output | RING_LOG2 | Companion data ring slot (zero when `IS_RX` is 0) |
| consumed_be | output | 32 | Consumed count, big-endian byte order |

## Verification
The hardest situation to reach from the ports is the 32-bit wrap of both counts. From a reset value of zero it would take four billion descriptors. The bench therefore builds the block with `START_COUNT` eight below the wrap point. It then rings doorbells that carry the producer count across zero, so consumption, slot masking and the distance check are all exercised on both sides of the wrap within a few hundred cycles. Rejected doorbells, both too far ahead and behind the consumed count, are checked by confirming that no descriptor appears afterwards.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PRESENT
    } cons_state_t;

    // Byte reversal between numeric value and big-endian lane order.
    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/ring_doorbell.sv
module ring_doorbell
    import ring_pkg::*;
#(
    parameter int unsigned RING_LOG2   = 4,
    parameter logic [31:0] START_COUNT = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        db_wr,
    input  logic [31:0] db_value_be,
    input  logic [31:0] tail,
    output logic [31:0] head,
    output logic        db_err
);
    localparam logic [31:0] RING_SIZE = 32'(1) << RING_LOG2;

    logic [31:0] req_value;
    logic [31:0] req_dist;
    logic        req_bad;

    always_comb begin
        req_value = swap_bytes(db_value_be);
        req_dist  = req_value - tail;   // modulo 2^32
        req_bad   = (req_dist > RING_SIZE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= START_COUNT;
            db_err <= 1'b0;
        end else begin
            db_err <= db_wr && req_bad;
            if (db_wr && !req_bad) begin
                head <= req_value;
            end
        end
    end

    // R8: a rejected doorbell leaves the producer count untouched
    p_head_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && req_bad) |=> $stable(head));

    // R8: an error pulse only follows a doorbell write
    p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        db_err |-> $past(db_wr));

endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
    import ring_pkg::*;
#(
    parameter int unsigned RING_LOG2   = 4,
    parameter int unsigned DESC_W      = 64,
    parameter logic [31:0] START_COUNT = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          head,
    output logic [31:0]          tail,
    output logic                 rd_en,
    output logic [RING_LOG2-1:0] rd_slot,
    input  logic [DESC_W-1:0]    rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DESC_W-1:0]    out_desc,
    output logic [RING_LOG2-1:0] out_slot
);
    cons_state_t state, state_nx;
    logic        work_pending;

    assign work_pending = (head != tail);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (work_pending) state_nx = ST_FETCH;
            ST_FETCH:   state_nx = ST_PRESENT;
            ST_PRESENT: if (out_ready) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // combinational outputs
    always_comb begin
        rd_en     = (state == ST_IDLE) && work_pending;
        rd_slot   = tail[RING_LOG2-1:0];
        out_valid = (state == ST_PRESENT);
    end

    // registered outputs and consumed count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail     <= START_COUNT;
            out_desc <= '0;
            out_slot <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    out_desc <= rd_data;
                    out_slot <= tail[RING_LOG2-1:0];
                end
                ST_PRESENT: if (out_ready) tail <= tail + 32'd1;
                default: ;
            endcase
        end
    end

    // R5: a stalled descriptor is held unchanged
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_desc) && $stable(out_slot)));

    // R6: the consumed count moves only on an accepted descriptor
    p_tail_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> $stable(tail));

    // R6: an accepted descriptor advances the count by one
    p_tail_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (tail == $past(tail) + 32'd1));

endmodule

// File: rtl/desc_ring_consumer.sv
module desc_ring_consumer
    import ring_pkg::*;
#(
    parameter int unsigned RING_LOG2   = 4,
    parameter int unsigned DESC_W      = 64,
    parameter bit          IS_RX       = 1'b1,
    parameter logic [31:0] START_COUNT = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 db_wr,
    input  logic [31:0]          db_value_be,
    output logic                 db_err,
    output logic                 mem_rd_en,
    output logic [RING_LOG2-1:0] mem_rd_slot,
    input  logic [DESC_W-1:0]    mem_rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DESC_W-1:0]    out_desc,
    output logic [RING_LOG2-1:0] out_slot,
    output logic [RING_LOG2-1:0] out_data_slot,
    output logic [31:0]          consumed_be
);
    localparam logic [31:0] RING_SIZE = 32'(1) << RING_LOG2;

    logic [31:0] head;
    logic [31:0] tail;

    ring_doorbell #(
        .RING_LOG2  (RING_LOG2),
        .START_COUNT(START_COUNT)
    ) u_bell (
        .clk        (clk),
        .rst_n      (rst_n),
        .db_wr      (db_wr),
        .db_value_be(db_value_be),
        .tail       (tail),
        .head       (head),
        .db_err     (db_err)
    );

    ring_fetch_fsm #(
        .RING_LOG2  (RING_LOG2),
        .DESC_W     (DESC_W),
        .START_COUNT(START_COUNT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .head     (head),
        .tail     (tail),
        .rd_en    (mem_rd_en),
        .rd_slot  (mem_rd_slot),
        .rd_data  (mem_rd_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_desc (out_desc),
        .out_slot (out_slot)
    );

    assign consumed_be = swap_bytes(tail);

    generate
        if (IS_RX) begin : g_rx
            assign out_data_slot = out_slot;
        end else begin : g_tx
            assign out_data_slot = '0;
        end
    endgenerate

    // R3: producer is never more than one ring ahead of the consumer
    p_pending_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head - tail) <= RING_SIZE);

endmodule

// File: tb/desc_ring_consumer_test.sv
module desc_ring_consumer_test;
    localparam int unsigned LOG2  = 4;
    localparam int unsigned DW    = 64;
    localparam logic [31:0] START = 32'hFFFF_FFF8;
    localparam logic [31:0] MASK  = (32'(1) << LOG2) - 32'd1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            db_wr = 1'b0;
    logic [31:0]     db_value_be = '0;
    logic            db_err;
    logic            mem_rd_en;
    logic [LOG2-1:0] mem_rd_slot;
    logic [DW-1:0]   mem_rd_data = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [DW-1:0]   out_desc;
    logic [LOG2-1:0] out_slot;
    logic [LOG2-1:0] out_data_slot;
    logic [31:0]     consumed_be;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] exp_count = START;

    always #5 clk = ~clk;

    desc_ring_consumer #(
        .RING_LOG2(LOG2), .DESC_W(DW), .IS_RX(1'b1), .START_COUNT(START)
    ) uut (
        .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_value_be(db_value_be),
        .db_err(db_err), .mem_rd_en(mem_rd_en), .mem_rd_slot(mem_rd_slot),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_desc(out_desc), .out_slot(out_slot), .out_data_slot(out_data_slot),
        .consumed_be(consumed_be)
    );

    function automatic logic [DW-1:0] mem_word(input logic [LOG2-1:0] s);
        return {32'hC0DE_0000 + 32'(s), 32'h1234_0000 + 32'(s) * 32'd3};
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // memory model with one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_slot);
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ring(input logic [31:0] value, input bit expect_err);
        @(negedge clk);
        db_wr = 1'b1;
        db_value_be = rev(value);
        @(negedge clk);
        db_wr = 1'b0;
        check("R8 db_err", 64'(db_err), 64'(expect_err));
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!out_valid) begin
            errors++;
            checks++;
            $display("FAIL %s actual=no descriptor expected=descriptor", req);
        end
    endtask

    task automatic consume(input int n, input bit stall);
        for (int k = 0; k < n; k++) begin
            logic [LOG2-1:0] es;
            es = exp_count[LOG2-1:0];
            wait_valid("R3 pending work");
            check("R4 slot", 64'(out_slot), 64'(es));
            check("R4 desc", out_desc, mem_word(es));
            check("R9 data slot", 64'(out_data_slot), 64'(es));
            if (stall) begin
                @(negedge clk);
                @(negedge clk);
                check("R5 held valid", 64'(out_valid), 64'd1);
                check("R5 held desc", out_desc, mem_word(es));
                check("R6 no advance while stalled", 64'(rev(consumed_be)), 64'(exp_count));
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            exp_count = exp_count + 32'd1;
            check("R6 consumed count", 64'(rev(consumed_be)), 64'(exp_count));
        end
    endtask

    task automatic expect_quiet(input string req);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(req, 64'(out_valid), 64'd0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 consumed", 64'(consumed_be), 64'h0000_0000_F8FF_FFFF);
        check("R2 byte order of count", 64'(rev(consumed_be)), 64'(START));
        check("R1 db_err", 64'(db_err), 64'd0);
        check("R1 no read", 64'(mem_rd_en), 64'd0);
        expect_quiet("R1 out_valid idle");
    endtask

    task automatic t_basic();
        ring(START + 32'd3, 1'b0);
        consume(3, 1'b0);
        expect_quiet("R3 nothing pending");
    endtask

    task automatic t_stall();
        ring(START + 32'd6, 1'b0);
        consume(3, 1'b1);
        expect_quiet("R5 no repeat after stall");
    endtask

    task automatic t_wrap();
        ring(START + 32'd18, 1'b0);
        consume(12, 1'b0);
        check("R7 count after wrap", 64'(rev(consumed_be)), 64'h0000_0000_0000_000A);
        expect_quiet("R7 pending across wrap");
    endtask

    task automatic t_bad_bell();
        ring(exp_count + 32'd17, 1'b1);
        expect_quiet("R8 too far ahead ignored");
        ring(exp_count - 32'd1, 1'b1);
        expect_quiet("R8 behind ignored");
        ring(exp_count + 32'd16, 1'b0);
        consume(16, 1'b0);
        expect_quiet("R4 full ring drained");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_stall();
        t_wrap();
        t_bad_bell();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule